// File: doc/BRIEF.md
# Dual-Port Memory with Per-Port Write Modes

A synchronous memory with two fully independent ports, A and B, that share one clock. Either port can read or write any word in a cycle. The read data of each port comes from an output register, so it appears one clock after the request. Any write on a port also reads the same address on that port. A parameter for each port sets what that port's output register takes during its own write: the word that was stored before the write, the word being written, or no change at all.

Both ports can address the same word in the same cycle, and every such case has a fixed result. Two reads return the same word. Two writes store port A's data, so equal data simply gets stored. When one port writes and the other reads, the write always completes. What the reader sees depends on the writer's mode. A one-cycle collision flag marks each cycle in which the two ports met on one address with at least one of them writing.

Top module: `dpram_modes`

## Requirements
- R1: An enabled port that is not writing, with no write from the other port to the same address, shows the stored word at that address on its output one clock later.
- R2: A writing port in read-first mode (mode value 0) shows, one clock later, the word stored at the address before the write.
- R3: A writing port in write-first mode (mode value 1) shows its own write data one clock later.
- R4: A writing port in no-change mode (mode value 2) keeps its output unchanged.
- R5: A port whose enable is low changes neither its output register nor the array, whatever its write enable, address and data are.
- R6: When both ports read the same address in the same cycle, both outputs show the same stored word one clock later.
- R7: When both ports write the same address in the same cycle, port A's data is stored; when the two data words are equal, that common word is stored.
- R8: When one port writes an address that the other port reads in the same cycle, the write is stored. The reader shows the new data if the writer is in write-first mode, and the old word if the writer is in read-first or no-change mode.
- R9: `collision` is high for exactly the one clock after a cycle in which both ports are enabled at the same address and at least one of them writes, and low after every other cycle.
- R10: While `rstN` is low at a clock edge, both outputs and `collision` are cleared to zero after that edge. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Synchronous reset, active low, for the output registers and the flag |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| addrA | input | ADDR_W | Port A word address |
| dinA | input | DATA_W | Port A write data |
| doutA | output | DATA_W | Port A registered read data |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| addrB | input | ADDR_W | Port B word address |
| dinB | input | DATA_W | Port B write data |
| doutB | output | DATA_W | Port B registered read data |
| collision | output | 1 | One-cycle same-address collision indication |

## Verification
The assertions assume the inputs are settled, 2-state values at each rising edge. They also assume that a port's output is only compared with stored contents once the word at that address has been written since power-up, because the array has no reset. The stimulus starts after reset by filling every word through both ports at distinct addresses, so every later read hits known data. The random phase then draws addresses from a narrow range about half of the time. This makes same-address reads, writes and mixed collisions common, while the values stay deterministic.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Per-port write-mode codes (parameter values)
  localparam int MODE_READ_FIRST  = 0;
  localparam int MODE_WRITE_FIRST = 1;
  localparam int MODE_NO_CHANGE   = 2;

  // Where an output register takes its next value from
  typedef enum logic [1:0] {
    SRC_OLD  = 2'd0,   // stored word before this cycle's writes
    SRC_OWN  = 2'd1,   // this port's write data
    SRC_PEER = 2'd2    // the other port's write data
  } srcSel_e;

  typedef struct packed {
    logic    load;     // update the output register
    srcSel_e sel;      // source when loading
    logic    store;    // write this port's data into the array
  } portStrobe_t;

  typedef struct packed {
    portStrobe_t pa;
    portStrobe_t pb;
    logic        collide;
  } dprStrobe_t;

endpackage

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int MODE_A = MODE_READ_FIRST,
  parameter int MODE_B = MODE_WRITE_FIRST
) (
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  output dprStrobe_t        strobe
);

  // Decision for one port given its own request and the peer's write on the same word
  function automatic portStrobe_t decide(
    input logic en, input logic we, input int ownMode,
    input logic peerHit, input int peerMode);
    portStrobe_t s;
    s.load  = 1'b0;
    s.sel   = SRC_OLD;
    s.store = 1'b0;
    if (en) begin
      if (we) begin
        s.store = 1'b1;
        unique case (ownMode)
          MODE_WRITE_FIRST: begin s.load = 1'b1; s.sel = SRC_OWN; end
          MODE_NO_CHANGE:   begin s.load = 1'b0; s.sel = SRC_OLD; end
          default:          begin s.load = 1'b1; s.sel = SRC_OLD; end
        endcase
      end else begin
        s.load = 1'b1;
        s.sel  = (peerHit && peerMode == MODE_WRITE_FIRST) ? SRC_PEER : SRC_OLD;
      end
    end
    return s;
  endfunction

  logic sameWord;
  logic aWrites;
  logic bWrites;
  portStrobe_t sa;
  portStrobe_t sb;

  always_comb begin
    sameWord = enA && enB && (addrA == addrB);
    aWrites  = enA && weA;
    bWrites  = enB && weB;
    sa = decide(enA, weA, MODE_A, sameWord && bWrites, MODE_B);
    sb = decide(enB, weB, MODE_B, sameWord && aWrites, MODE_A);
    // Port A has priority on a same-word double write
    if (sameWord && aWrites) sb.store = 1'b0;
    strobe.pa      = sa;
    strobe.pb      = sb;
    strobe.collide = sameWord && (weA || weB);
  end

endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dprStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutA,
  output logic [DATA_W-1:0] doutB,
  output logic              colFlag
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPORT = 2;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] portAddr [NPORT];
  logic [DATA_W-1:0] portDin  [NPORT];
  logic [DATA_W-1:0] portOut  [NPORT];
  portStrobe_t       portStb  [NPORT];

  assign portAddr[0] = addrA;
  assign portAddr[1] = addrB;
  assign portDin[0]  = dinA;
  assign portDin[1]  = dinB;
  assign portStb[0]  = strobe.pa;
  assign portStb[1]  = strobe.pb;

  // Array: B first, then A, so A wins any overlap (control also masks B then)
  always_ff @(posedge clk) begin
    if (portStb[1].store) mem[portAddr[1]] <= portDin[1];
    if (portStb[0].store) mem[portAddr[0]] <= portDin[0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [DATA_W-1:0] oldWord;
    logic [DATA_W-1:0] nextOut;

    assign oldWord = mem[portAddr[p]];

    always_comb begin
      unique case (portStb[p].sel)
        SRC_OWN:  nextOut = portDin[p];
        SRC_PEER: nextOut = portDin[NPORT-1-p];
        default:  nextOut = oldWord;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)                portOut[p] <= '0;
      else if (portStb[p].load) portOut[p] <= nextOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) colFlag <= 1'b0;
    else       colFlag <= strobe.collide;
  end

  assign doutA = portOut[0];
  assign doutB = portOut[1];

endmodule

// File: rtl/dpram_modes.sv
module dpram_modes
  import dpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int MODE_A = MODE_READ_FIRST,
  parameter int MODE_B = MODE_WRITE_FIRST
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  output logic [DATA_W-1:0] doutA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutB,
  output logic              collision
);

  dprStrobe_t strobe;

  dpr_ctrl #(
    .ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) uCtrl (
    .enA(enA), .weA(weA), .addrA(addrA),
    .enB(enB), .weB(weB), .addrB(addrB),
    .strobe(strobe)
  );

  dpr_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .addrA(addrA), .dinA(dinA), .addrB(addrB), .dinB(dinB),
    .doutA(doutA), .doutB(doutB), .colFlag(collision)
  );

endmodule

// File: rtl/dpram_modes_chk.sv
module dpram_modes_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int MODE_A = 0,
  parameter int MODE_B = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              enA,
  input logic              weA,
  input logic [ADDR_W-1:0] addrA,
  input logic [DATA_W-1:0] dinA,
  input logic [DATA_W-1:0] doutA,
  input logic              enB,
  input logic              weB,
  input logic [ADDR_W-1:0] addrB,
  input logic [DATA_W-1:0] dinB,
  input logic [DATA_W-1:0] doutB,
  input logic              collision
);

  logic meet;
  assign meet = enA && enB && (addrA == addrB);

  // R9: flag follows a collision cycle, and only such a cycle
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (meet && (weA || weB)) |=> collision);
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    !(meet && (weA || weB)) |=> !collision);

  // R5: disabled port holds its output
  a_r5_hold_a: assert property (@(posedge clk) disable iff (!rstN)
    !enA |=> $stable(doutA));
  a_r5_hold_b: assert property (@(posedge clk) disable iff (!rstN)
    !enB |=> $stable(doutB));

  // R3: write-first port shows its own data
  a_r3_wf_a: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_A == 1 && enA && weA) |=> doutA == $past(dinA));
  a_r3_wf_b: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_B == 1 && enB && weB) |=> doutB == $past(dinB));

  // R4: no-change port keeps its output while writing
  a_r4_nc_a: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_A == 2 && enA && weA) |=> $stable(doutA));
  a_r4_nc_b: assert property (@(posedge clk) disable iff (!rstN)
    (MODE_B == 2 && enB && weB) |=> $stable(doutB));

  // R6: same-word double read gives equal outputs
  a_r6_same_read: assert property (@(posedge clk) disable iff (!rstN)
    (meet && !weA && !weB) |=> doutA == doutB);

  // R10: cleared after a reset edge
  logic wasReset;
  always_ff @(posedge clk) begin
    wasReset <= !rstN;
    if (wasReset) begin
      a_r10_cleared: assert (doutA == '0 && doutB == '0 && !collision);
    end
  end

endmodule

bind dpram_modes dpram_modes_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
) uChk (
  .clk(clk), .rstN(rstN),
  .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA), .doutA(doutA),
  .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB), .doutB(doutB),
  .collision(collision)
);

// File: tb/sim_dpram_modes.sv
`timescale 1ns/1ps
module sim_dpram_modes;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NI = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enA = 0, weA = 0, enB = 0, weB = 0;
  logic [AW-1:0] addrA = '0, addrB = '0;
  logic [DW-1:0] dinA = '0, dinB = '0;
  logic [DW-1:0] doutA [NI];
  logic [DW-1:0] doutB [NI];
  logic colOut [NI];

  always #2 clk = ~clk;

  // u0: A read-first, B write-first ; u1: A no-change, B read-first
  dpram_modes #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(0), .MODE_B(1)) u0 (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA),
    .doutA(doutA[0]), .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB),
    .doutB(doutB[0]), .collision(colOut[0]));
  dpram_modes #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(2), .MODE_B(0)) u1 (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA),
    .doutA(doutA[1]), .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB),
    .doutB(doutB[1]), .collision(colOut[1]));

  int modeA [NI] = '{0, 2};
  int modeB [NI] = '{1, 0};

  // Bench model
  logic [DW-1:0] mdl [NI][DEPTH];
  bit known [NI][DEPTH];
  bit dualMark [NI][DEPTH];
  logic [DW-1:0] expA [NI], expB [NI];
  bit knA [NI], knB [NI];
  bit expCol;
  string tagA [NI], tagB [NI];
  int checks = 0, errors = 0;

  function automatic string ownTag(int m);
    return (m == 1) ? "R3" : (m == 2) ? "R4" : "R2";
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compute expected results for the current inputs, then update the model
  task automatic modelStep();
    bit same;
    same = enA && enB && addrA == addrB;
    expCol = same && (weA || weB);
    for (int k = 0; k < NI; k++) begin
      logic [DW-1:0] oldA, oldB;
      bit kOA, kOB;
      oldA = mdl[k][addrA]; kOA = known[k][addrA];
      oldB = mdl[k][addrB]; kOB = known[k][addrB];
      // Port A
      if (!enA) tagA[k] = "R5";
      else if (weA) begin
        tagA[k] = ownTag(modeA[k]);
        if (modeA[k] == 0) begin expA[k] = oldA; knA[k] = kOA; end
        else if (modeA[k] == 1) begin expA[k] = dinA; knA[k] = 1; end
      end else if (same && weB) begin
        tagA[k] = "R8";
        if (modeB[k] == 1) begin expA[k] = dinB; knA[k] = 1; end
        else begin expA[k] = oldA; knA[k] = kOA; end
      end else begin
        tagA[k] = same ? "R6" : (dualMark[k][addrA] ? "R7" : "R1");
        expA[k] = oldA; knA[k] = kOA;
      end
      // Port B
      if (!enB) tagB[k] = "R5";
      else if (weB) begin
        tagB[k] = ownTag(modeB[k]);
        if (modeB[k] == 0) begin expB[k] = oldB; knB[k] = kOB; end
        else if (modeB[k] == 1) begin expB[k] = dinB; knB[k] = 1; end
      end else if (same && weA) begin
        tagB[k] = "R8";
        if (modeA[k] == 1) begin expB[k] = dinA; knB[k] = 1; end
        else begin expB[k] = oldB; knB[k] = kOB; end
      end else begin
        tagB[k] = same ? "R6" : (dualMark[k][addrB] ? "R7" : "R1");
        expB[k] = oldB; knB[k] = kOB;
      end
      // Array (A stored last so it wins)
      if (enB && weB) begin
        mdl[k][addrB] = dinB; known[k][addrB] = 1; dualMark[k][addrB] = 0;
      end
      if (enA && weA) begin
        mdl[k][addrA] = dinA; known[k][addrA] = 1;
        dualMark[k][addrA] = same && weB;
      end
    end
  endtask

  // Drive one cycle at a falling edge, compare after the next falling edge
  task automatic cyc(bit ea, bit wa, int aa, int da, bit eb, bit wb, int ab, int db);
    enA = ea; weA = wa; addrA = AW'(aa); dinA = DW'(da);
    enB = eb; weB = wb; addrB = AW'(ab); dinB = DW'(db);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      if (knA[k]) check(tagA[k], $sformatf("u%0d doutA", k), doutA[k], expA[k]);
      if (knB[k]) check(tagB[k], $sformatf("u%0d doutB", k), doutB[k], expB[k]);
      check("R9", $sformatf("u%0d collision", k), DW'(colOut[k]), DW'(expCol));
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < NI; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        known[k][i] = 0; dualMark[k][i] = 0; mdl[k][i] = '0;
      end
      knA[k] = 0; knB[k] = 0; expA[k] = '0; expB[k] = '0;
    end
    // R10: reset clears outputs and flag
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      check("R10", $sformatf("u%0d doutA reset", k), doutA[k], '0);
      check("R10", $sformatf("u%0d doutB reset", k), doutB[k], '0);
      check("R10", $sformatf("u%0d collision reset", k), DW'(colOut[k]), '0);
      knA[k] = 1; knB[k] = 1;
    end
    rstN = 1'b1;
    // Fill every word through both ports at distinct addresses
    for (int i = 0; i < DEPTH / 2; i++)
      cyc(1, 1, i, 16'h1000 + i, 1, 1, i + DEPTH / 2, 16'h2000 + i);
    // R1 plain reads
    cyc(1, 0, 3, 0, 1, 0, 12, 0);
    // R6 same-word double read
    cyc(1, 0, 5, 0, 1, 0, 5, 0);
    // R7 unequal double write, then read back
    cyc(1, 1, 6, 16'hAAAA, 1, 1, 6, 16'h5555);
    cyc(1, 0, 6, 0, 0, 0, 0, 0);
    // R7 equal double write
    cyc(1, 1, 7, 16'h7777, 1, 1, 7, 16'h7777);
    cyc(0, 0, 0, 0, 1, 0, 7, 0);
    // R8 A writes, B reads same word; then B writes, A reads
    cyc(1, 1, 9, 16'hBEEF, 1, 0, 9, 0);
    cyc(1, 0, 10, 0, 1, 1, 10, 16'hCAFE);
    cyc(1, 0, 9, 0, 1, 0, 10, 0);
    // R5 disabled ports with write enable set: outputs and array untouched
    cyc(0, 1, 2, 16'hDEAD, 0, 1, 11, 16'hDEAD);
    cyc(1, 0, 2, 0, 1, 0, 11, 0);
    // Random mix, narrow address range half of the time
    for (int n = 0; n < 4000; n++) begin
      int aa, ab;
      bit narrow;
      narrow = $urandom_range(1);
      aa = narrow ? $urandom_range(3) : $urandom_range(DEPTH - 1);
      ab = narrow ? $urandom_range(3) : $urandom_range(DEPTH - 1);
      cyc($urandom_range(7) != 0, $urandom_range(1), aa, $urandom_range(16'hFFFF),
          $urandom_range(7) != 0, $urandom_range(1), ab, $urandom_range(16'hFFFF));
    end
    // R10 again: mid-run reset
    rstN = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      check("R10", $sformatf("u%0d doutA rerun", k), doutA[k], '0);
      check("R10", $sformatf("u%0d doutB rerun", k), doutB[k], '0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule